// File: doc/BRIEF.md
# Stream Link Read Unit

This unit executes the processor's "get" operation against a set of inbound stream links. Each link offers a 32-bit word, a tag flag that marks the word as data or control, and a valid flag. The unit drives a one-cycle read strobe back to the link it pops. The pipeline hands the unit a raw instruction word, a request-valid flag and the current user-mode state. The unit decodes the option bits from the word and either completes the access in the same cycle, stalls the pipeline, or raises an exception.

The options are as follows. Blocking or polling decides what happens when no word is present. The data or control expectation is compared against the link's tag. A trap option diverts a mismatching word into an exception data register instead of the destination register. A peek option completes normally but leaves the word in the link. An atomic option holds off interrupts while the request is active. A privilege check, enabled by parameters, rejects user-mode accesses before any link is touched. A sticky error flag records every tag mismatch until it is cleared by a dedicated input.

Top module: `streamGetUnit`

## Requirements
- R1: A request is acted on only when reqValid is high, instruction bits [31:26] equal 6'b011011, and the reserved bits [20:16] and [10:4] are all zero. Otherwise every output stays idle: no stall, no write-back, no carry, no read strobe, no exception, no inhibit. The field positions, using LSB-0 numbering, are: destination register [25:21], non-blocking [15], control-type [14], peek [13], atomic [12], trap [11], link index [3:0].
- R2: A link index greater than or equal to NUM_LINKS selects link 0. This applies to data, valid, tag, read strobe and the reported link index.
- R3: A blocking request holds stall high while the selected link's valid is low. It completes, with no stall, in the cycle valid is high.
- R4: A non-blocking request never stalls. It raises carryEn with carryOut=0 when the selected link is valid and carryOut=1 when it is not. wbEn is still asserted on a failed poll, and the data on that path is unspecified.
- R5: On a consumed word, a data-type request (control-type bit 0) expects tag 0, and a control-type request expects tag 1. A mismatch sets streamErr from the next cycle.
- R6: streamErr stays set until errClear is sampled high with no new mismatch in that cycle. A matching access does not clear it.
- R7: A mismatch on a request with the trap bit set asserts excValid with excCause=0 and excLink equal to the selected link. wbEn stays low, and excData holds the consumed word from the next cycle. excData changes at no other time.
- R8: A peek request behaves like a normal request, but linkRead stays all zero.
- R9: intInhibit is high whenever a decoded request has the atomic bit set, including in stall cycles.
- R10: When PRIV_CHECK is on and userMode is high, a decoded request raises excValid with excCause=7 and excLink=0. It has no read strobe, no write-back, no carry, no stall and no streamErr update, even if a tag mismatch is present.
- R11: linkRead is one-hot or zero. A bit is high only in the cycle its link's valid word is consumed.
- R12: On a successful write-back of a consumed word, wbData equals the selected link's word and wbReg equals the instruction's destination field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Get request present this cycle |
| reqInstr | input | 32 | Raw instruction word |
| userMode | input | 1 | Processor is in user mode |
| errClear | input | 1 | Clears the sticky stream-error flag |
| linkData | input | NUM_LINKS*32 | Words offered by the links, link 0 in the low bits |
| linkCtrl | input | NUM_LINKS | Tag of each link's word (1 = control) |
| linkValid | input | NUM_LINKS | Each link holds a word |
| linkRead | output | NUM_LINKS | Pop strobe per link |
| stall | output | 1 | Hold the pipeline |
| wbEn | output | 1 | Write wbData into register wbReg |
| wbReg | output | 5 | Destination register index |
| wbData | output | 32 | Write-back value |
| carryEn | output | 1 | Update carry with carryOut |
| carryOut | output | 1 | 1 when a poll found no word |
| streamErr | output | 1 | Sticky tag-mismatch flag |
| excValid | output | 1 | Exception raised this cycle |
| excCause | output | 5 | Exception cause code (0 stream, 7 privilege) |
| excLink | output | 4 | Link index reported with the exception |
| excData | output | 32 | Exception data register |
| intInhibit | output | 1 | Block interrupts for an atomic request |

## Verification
A wrong link-select or decode state shows in the same cycle. The wrong read strobe, write-back data, stall or carry appears before the next clock edge, so each randomized request is compared at once. A corrupted sticky flag or exception data register shows one cycle after the edge that should have updated it. A lost set or a spurious clear persists until the next mismatch or clear, so the flag is compared after every request. Directed sequences cover the stall-then-arrive case, out-of-range link indices, and the privilege fault masking a mismatch.

// File: rtl/streamGetPkg.sv
package streamGetPkg;
  localparam int DATA_W = 32;
  localparam int IDX_W = 4;
  localparam int CAUSE_W = 5;
  localparam logic [5:0] OPC_GET = 6'b011011;
  localparam logic [CAUSE_W-1:0] CAUSE_STREAM = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_PRIV = 5'd7;

  // LSB-0 positions of the option bits
  localparam int POS_NB = 15;
  localparam int POS_CTL = 14;
  localparam int POS_PEEK = 13;
  localparam int POS_ATOM = 12;
  localparam int POS_TRAP = 11;

  typedef struct packed {
    logic wbEn;
    logic errSet;
    logic edrLoad;
  } dpStrobe_t;

  typedef struct packed {
    logic       hit;
    logic [4:0] rd;
    logic       nb;
    logic       ctl;
    logic       peek;
    logic       atom;
    logic       trap;
    logic [IDX_W-1:0] idx;
  } getReq_t;

  function automatic getReq_t decodeGet(input logic vld, input logic [31:0] w);
    getReq_t r;
    r.hit  = vld && (w[31:26] == OPC_GET) && (w[20:16] == 5'd0) && (w[10:4] == 7'd0);
    r.rd   = w[25:21];
    r.nb   = w[POS_NB];
    r.ctl  = w[POS_CTL];
    r.peek = w[POS_PEEK];
    r.atom = w[POS_ATOM];
    r.trap = w[POS_TRAP];
    r.idx  = w[IDX_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/streamGetCtrl.sv
module streamGetCtrl
  import streamGetPkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter bit PRIV_CHECK = 1'b1,
  parameter int SEL_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [31:0]           reqInstr,
  input  logic                  userMode,
  input  logic [NUM_LINKS-1:0]  linkValid,
  input  logic [NUM_LINKS-1:0]  linkCtrl,
  output logic [NUM_LINKS-1:0]  linkRead,
  output logic                  stall,
  output logic                  carryEn,
  output logic                  carryOut,
  output logic                  excValid,
  output logic [CAUSE_W-1:0]    excCause,
  output logic [IDX_W-1:0]      excLink,
  output logic                  intInhibit,
  output logic [4:0]            wbReg,
  output logic [SEL_W-1:0]      selIdx,
  output dpStrobe_t             strb
);
  localparam logic [IDX_W:0] LINK_LIMIT = (IDX_W+1)'(NUM_LINKS);

  getReq_t req;
  logic [IDX_W-1:0] selFull;
  logic privFault, access, selValid, selTag, consume, mismatch, takeExc;

  always_comb begin
    req       = decodeGet(reqValid, reqInstr);
    privFault = req.hit && PRIV_CHECK && userMode;
    access    = req.hit && !privFault;
    selFull   = ({1'b0, req.idx} < LINK_LIMIT) ? req.idx : '0;
    selIdx    = selFull[SEL_W-1:0];
    selValid  = linkValid[selIdx];
    selTag    = linkCtrl[selIdx];
    consume   = access && selValid;
    mismatch  = consume && (selTag != req.ctl);
    takeExc   = mismatch && req.trap;
  end

  always_comb begin
    stall        = access && !req.nb && !selValid;
    carryEn      = access && req.nb;
    carryOut     = carryEn && !selValid;
    strb.wbEn    = access && (req.nb || selValid) && !takeExc;
    strb.errSet  = mismatch;
    strb.edrLoad = takeExc;
    excValid     = privFault || takeExc;
    excCause     = privFault ? CAUSE_PRIV : CAUSE_STREAM;
    excLink      = privFault ? '0 : selFull;
    intInhibit   = req.hit && req.atom;
    wbReg        = req.rd;
  end

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_read
    assign linkRead[i] = consume && !req.peek && (selIdx == SEL_W'(i));
  end

  AST_READ_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(linkRead)); // R11
  AST_READ_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (linkRead & ~linkValid) == '0); // R11
  AST_STALL_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (linkRead == '0)); // R3
  AST_PRIV_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excCause == CAUSE_PRIV) |-> (linkRead == '0 && !stall)); // R10
  AST_STALL_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !carryEn); // R4
endmodule

// File: rtl/streamGetDatapath.sv
module streamGetDatapath
  import streamGetPkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int SEL_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_LINKS*DATA_W-1:0] linkData,
  input  logic [SEL_W-1:0]            selIdx,
  input  dpStrobe_t                   strb,
  input  logic                        errClear,
  output logic                        wbEn,
  output logic [DATA_W-1:0]           wbData,
  output logic                        streamErr,
  output logic [DATA_W-1:0]           excData
);
  logic [DATA_W-1:0] selWord;

  always_comb begin
    selWord = linkData[selIdx*DATA_W +: DATA_W];
    wbData  = selWord;
    wbEn    = strb.wbEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      streamErr <= 1'b0;
      excData   <= '0;
    end else begin
      if (strb.errSet) streamErr <= 1'b1;
      else if (errClear) streamErr <= 1'b0;
      if (strb.edrLoad) excData <= selWord;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (streamErr && !errClear) |=> streamErr); // R6
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.errSet |=> streamErr); // R5
  AST_WB_OR_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.edrLoad |-> !strb.wbEn); // R7
  AST_EDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.edrLoad |=> $stable(excData)); // R7
endmodule

// File: rtl/streamGetUnit.sv
module streamGetUnit
  import streamGetPkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter bit USE_MMU = 1'b1,
  parameter bit MMU_PRIV_ALLOW = 1'b0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [31:0]                 reqInstr,
  input  logic                        userMode,
  input  logic                        errClear,
  input  logic [NUM_LINKS*DATA_W-1:0] linkData,
  input  logic [NUM_LINKS-1:0]        linkCtrl,
  input  logic [NUM_LINKS-1:0]        linkValid,
  output logic [NUM_LINKS-1:0]        linkRead,
  output logic                        stall,
  output logic                        wbEn,
  output logic [4:0]                  wbReg,
  output logic [DATA_W-1:0]           wbData,
  output logic                        carryEn,
  output logic                        carryOut,
  output logic                        streamErr,
  output logic                        excValid,
  output logic [CAUSE_W-1:0]          excCause,
  output logic [IDX_W-1:0]            excLink,
  output logic [DATA_W-1:0]           excData,
  output logic                        intInhibit
);
  localparam int SEL_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1;
  localparam bit PRIV_CHECK = USE_MMU && !MMU_PRIV_ALLOW;

  dpStrobe_t strb;
  logic [SEL_W-1:0] selIdx;

  streamGetCtrl #(.NUM_LINKS(NUM_LINKS), .PRIV_CHECK(PRIV_CHECK), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqInstr(reqInstr),
    .userMode(userMode), .linkValid(linkValid), .linkCtrl(linkCtrl),
    .linkRead(linkRead), .stall(stall), .carryEn(carryEn), .carryOut(carryOut),
    .excValid(excValid), .excCause(excCause), .excLink(excLink),
    .intInhibit(intInhibit), .wbReg(wbReg), .selIdx(selIdx), .strb(strb)
  );

  streamGetDatapath #(.NUM_LINKS(NUM_LINKS), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .linkData(linkData), .selIdx(selIdx), .strb(strb),
    .errClear(errClear), .wbEn(wbEn), .wbData(wbData), .streamErr(streamErr),
    .excData(excData)
  );

  AST_NO_WB_ON_EXC: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> !wbEn); // R7
  AST_NO_WB_ON_STALL: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (!wbEn && !excValid)); // R3
endmodule

// File: tb/sim_streamGetUnit.sv
module sim_streamGetUnit;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [31:0] reqInstr = '0;
  logic userMode = 1'b0;
  logic errClear = 1'b0;
  logic [NL*32-1:0] linkData = '0;
  logic [NL-1:0] linkCtrl = '0;
  logic [NL-1:0] linkValid = '0;
  logic [NL-1:0] linkRead;
  logic stall, wbEn, carryEn, carryOut, streamErr, excValid, intInhibit;
  logic [4:0] wbReg, excCause;
  logic [3:0] excLink;
  logic [31:0] wbData, excData;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit expErr = 0;
  logic [31:0] expEdr = '0;

  always #2.5 clk = ~clk;

  streamGetUnit #(.NUM_LINKS(NL)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] rd, input bit nb, input bit c,
                                      input bit t, input bit a, input bit e, input logic [3:0] idx);
    return {6'b011011, rd, 5'd0, nb, c, t, a, e, 7'd0, idx};
  endfunction

  task automatic runOp(input logic rv, input logic [31:0] ins, input logic um,
                       input logic [NL-1:0] vld, input logic [NL-1:0] ctl, input logic clr);
    bit opOk, priv, acc, v, tg, nb, c, t, a, e, mism, trap;
    int sel;
    logic [31:0] word;
    logic [NL-1:0] eRead;
    bit eStall, eWb, eCen;
    @(negedge clk);
    reqValid = rv; reqInstr = ins; userMode = um; linkValid = vld; linkCtrl = ctl; errClear = clr;
    for (int k = 0; k < NL; k++) linkData[k*32 +: 32] = $urandom;
    opOk = rv && ins[31:26] == 6'b011011 && ins[20:16] == 0 && ins[10:4] == 0;
    priv = opOk && um;
    acc = opOk && !priv;
    sel = (ins[3:0] < NL) ? int'(ins[3:0]) : 0;
    nb = ins[15]; c = ins[14]; t = ins[13]; a = ins[12]; e = ins[11];
    v = vld[sel]; tg = ctl[sel];
    word = linkData[sel*32 +: 32];
    mism = acc && v && (tg != c);
    trap = mism && e;
    eStall = acc && !nb && !v;
    eWb = acc && (nb || v) && !trap;
    eCen = acc && nb;
    eRead = (acc && v && !t) ? NL'(1 << sel) : '0;
    #1;
    chk(stall == eStall, "R3 stall", 32'(stall), 32'(eStall));
    chk(wbEn == eWb, "R1/R7 wbEn", 32'(wbEn), 32'(eWb));
    if (eWb && v) begin
      chk(wbData == word, "R12 R2 wbData", wbData, word);
      chk(wbReg == ins[25:21], "R12 wbReg", 32'(wbReg), 32'(ins[25:21]));
    end
    chk(carryEn == eCen, "R4 carryEn", 32'(carryEn), 32'(eCen));
    if (eCen) chk(carryOut == !v, "R4 carryOut", 32'(carryOut), 32'(!v));
    chk(linkRead == eRead, "R11 R8 R2 linkRead", 32'(linkRead), 32'(eRead));
    chk(excValid == (priv || trap), "R7 R10 excValid", 32'(excValid), 32'(priv || trap));
    if (priv) begin
      chk(excCause == 5'd7, "R10 cause", 32'(excCause), 32'd7);
      chk(excLink == 4'd0, "R10 link", 32'(excLink), 32'd0);
    end else if (trap) begin
      chk(excCause == 5'd0, "R7 cause", 32'(excCause), 32'd0);
      chk(excLink == 4'(sel), "R7 R2 link", 32'(excLink), 32'(sel));
    end
    chk(intInhibit == (opOk && a), "R9 intInhibit", 32'(intInhibit), 32'(opOk && a));
    if (mism) expErr = 1;
    else if (clr) expErr = 0;
    if (trap) expEdr = word;
    @(posedge clk); #1;
    chk(streamErr == expErr, "R5 R6 streamErr", 32'(streamErr), 32'(expErr));
    chk(excData == expEdr, "R7 excData", excData, expEdr);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(streamErr == 0, "reset streamErr", 32'(streamErr), 0);
    chk(excData == 0, "reset excData", excData, 0);
    @(negedge clk); rstN = 1'b1;
    // R1: no request, bad opcode, reserved bit set
    runOp(0, mk(5'd3, 0, 0, 0, 1, 0, 4'd1), 0, '1, '0, 0);
    runOp(1, mk(5'd3, 0, 0, 0, 1, 0, 4'd1) ^ 32'h0400_0000, 0, '1, '0, 0);
    runOp(1, mk(5'd3, 0, 0, 0, 1, 0, 4'd1) | 32'h0000_0010, 0, '1, '0, 0);
    // R3: blocking stall, then arrival
    runOp(1, mk(5'd4, 0, 0, 0, 0, 0, 4'd2), 0, 4'b1011, '0, 0);
    runOp(1, mk(5'd4, 0, 0, 0, 0, 0, 4'd2), 0, 4'b0100, '0, 0);
    // R2: out-of-range picks link 0; in-range top link
    runOp(1, mk(5'd5, 1, 0, 0, 0, 0, 4'd9), 0, 4'b0001, '0, 0);
    runOp(1, mk(5'd5, 0, 0, 0, 0, 0, 4'd15), 0, 4'b1110, '0, 0);
    runOp(1, mk(5'd5, 0, 0, 0, 0, 0, 4'd3), 0, 4'b1000, '0, 0);
    // R4: poll miss
    runOp(1, mk(5'd6, 1, 0, 0, 0, 0, 4'd1), 0, 4'b1101, '0, 0);
    // R5 R6: mismatch, then matching access keeps flag, then clear
    runOp(1, mk(5'd7, 0, 1, 0, 0, 0, 4'd1), 0, '1, 4'b0000, 0);
    runOp(1, mk(5'd7, 0, 0, 0, 0, 0, 4'd1), 0, '1, 4'b0000, 0);
    runOp(0, '0, 0, '0, '0, 1);
    // R7: trap; R8 peek; R9 atomic stall
    runOp(1, mk(5'd8, 0, 0, 0, 0, 1, 4'd2), 0, '1, 4'b0100, 0);
    runOp(1, mk(5'd8, 0, 1, 1, 0, 0, 4'd2), 0, '1, 4'b0100, 0);
    runOp(1, mk(5'd8, 0, 0, 0, 1, 0, 4'd0), 0, '0, '0, 0);
    // R10: privilege fault wins over mismatch with trap
    runOp(1, mk(5'd9, 0, 1, 0, 0, 1, 4'd3), 1, '1, '0, 1);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] w;
      w = mk(5'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), 4'($urandom));
      if ($urandom_range(0, 15) == 0) w = w ^ (32'd1 << $urandom_range(4, 31));
      runOp(1'($urandom_range(0, 7) != 0), w, $urandom_range(0, 7) == 0,
            NL'($urandom), NL'($urandom), $urandom_range(0, 5) == 0);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule